// File: doc/BRIEF.md
# Performance Monitor Register Bank with User Access Gate

This block holds the performance-monitor state of a core: three 64-bit control registers (control 0, control 1, control 2) and six 64-bit counters (counter 1 to counter 6). It sits behind a special-register read/write port. Here the counters are plain loadable registers and do not count events. Every request carries a problem-state flag. A privileged request reads and writes any register in full. A problem-state request must pass a check against a two-bit user-gate field held in control 0. It then sees the control registers only through fixed bit masks.

A problem-state request that fails the check does not complete. It produces a one-cycle trap pulse with a cause bit and leaves all registers unchanged. Problem-state code uses alias register numbers, and each alias sits exactly 0x10 below the privileged number of the same register.

The port accepts one request per cycle and has no back-pressure. `req_valid` qualifies a request, and there is no ready signal because the bank is never busy. Exactly one of `rsp_valid` or `trap_valid` pulses on the clock edge that accepts the request.

Top module: `pmu_gate`

## Requirements
- R1: A problem-state read of control 0, control 2 or counters 1 to 4 traps with cause 0 (facility unavailable) when the gate field (control 0 bits 19:18) is 01. For the gate values 00, 10 and 11 the read completes.
- R2: A problem-state write to control 0, control 2 or counters 1 to 4 completes only when the gate is 10 or 11. Gate 01 traps with cause 0, and gate 00 traps with cause 1 (emulation assist).
- R3: With the gate at 11, any problem-state read or write of counter 5 or counter 6 traps with cause 0. With any other gate value, counters 5 and 6 obey R1 and R2.
- R4: A problem-state read of control 0 returns bits 31, 26 and 7 of the register. Every other bit reads as zero.
- R5: A problem-state write of control 0 produces (old AND NOT m) OR (wdata AND m), where m has only bits 31, 26 and 7 set. This means the gate field cannot be changed from problem state.
- R6: Problem-state access to control 2 is limited to bits 62, 53, 44, 35, 26 and 17. Other bits read as zero and are kept on write.
- R7: The privileged numbers are: control 2 = 0x11, counters 1 to 6 = 0x13 to 0x18, control 0 = 0x1B, control 1 = 0x1E. A problem-state request addresses a register by its privileged number minus 0x10. Counters and control 2 have no user mask, so a problem-state counter write loads the full value.
- R8: A privileged request ignores the gate and the masks. It accepts both the privileged number and the alias number of every register.
- R9: A trapped request gives `trap_valid` high for exactly one cycle with `trap_cause`, `rsp_valid` low and `rsp_rdata` zero. No register changes.
- R10: The following numbers are unmapped: control 1's alias (0x0E) and any privileged number when used in problem state, and any unlisted number. An unmapped request completes with `rsp_valid` and zero data, raises no trap and changes no register.
- R11: After reset, all registers and outputs are zero. The response to a request appears on the first clock edge after it is presented, and each response pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = problem state, 0 = privileged |
| req_num | input | 8 | Register number |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Request completed (one-cycle pulse) |
| rsp_rdata | output | 64 | Read data, zero for writes, traps and unmapped numbers |
| trap_valid | output | 1 | Request trapped (one-cycle pulse) |
| trap_cause | output | 1 | 0 = facility unavailable, 1 = emulation assist |

## Verification
The assertions assume that `req_write`, `req_user`, `req_num` and `req_wdata` are stable around the edge that samples a valid request, and that reset is held for at least one edge. The stimulus meets this by changing inputs only on the falling clock edge. It keeps `req_valid` low during reset and on idle cycles. The gate field is moved only by privileged writes, so each gate value is set up before the problem-state requests that depend on it.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  localparam int DATA_W    = 64;
  localparam int NUM_W     = 8;
  localparam int NCNT      = 6;
  localparam int NCNT_LO   = 4;       // counters that stay available at gate 11
  localparam int NREG      = 3 + NCNT;
  localparam int IDX_W     = $clog2(NREG + 1);
  localparam int ALIAS_OFS = 16;
  localparam int GATE_LSB  = 18;
  localparam int FRZ_BIT   = 31;
  localparam int AEN_BIT   = 26;
  localparam int ALRT_BIT  = 7;
  localparam int C2_FIRST  = 17;
  localparam int C2_STEP   = 9;
  localparam int C2_COUNT  = 6;

  localparam int PN_CTRL2 = 'h11;
  localparam int PN_CNT1  = 'h13;
  localparam int PN_CTRL0 = 'h1B;
  localparam int PN_CTRL1 = 'h1E;

  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t IX_CTRL0 = idx_t'(0);
  localparam idx_t IX_CTRL1 = idx_t'(1);
  localparam idx_t IX_CTRL2 = idx_t'(2);
  localparam idx_t IX_CNT1  = idx_t'(3);
  localparam idx_t IX_HI    = idx_t'(3 + NCNT_LO);
  localparam idx_t IX_NONE  = idx_t'(NREG);

  typedef enum logic {CAUSE_FAC = 1'b0, CAUSE_EMU = 1'b1} cause_e;

  function automatic logic [DATA_W-1:0] user_mask(idx_t ix);
    logic [DATA_W-1:0] m;
    m = '1;
    if (ix == IX_CTRL0) begin
      m = '0;
      m[FRZ_BIT]  = 1'b1;
      m[AEN_BIT]  = 1'b1;
      m[ALRT_BIT] = 1'b1;
    end else if (ix == IX_CTRL2) begin
      m = '0;
      for (int k = 0; k < C2_COUNT; k++) m[C2_FIRST + k*C2_STEP] = 1'b1;
    end
    return m;
  endfunction

  function automatic idx_t lookup(logic [NUM_W-1:0] n);
    idx_t r;
    r = IX_NONE;
    if (n == NUM_W'(PN_CTRL0)) r = IX_CTRL0;
    if (n == NUM_W'(PN_CTRL1)) r = IX_CTRL1;
    if (n == NUM_W'(PN_CTRL2)) r = IX_CTRL2;
    for (int k = 0; k < NCNT; k++)
      if (n == NUM_W'(PN_CNT1 + k)) r = idx_t'(int'(IX_CNT1) + k);
    return r;
  endfunction
endpackage

// File: rtl/pmu_num_decode.sv
module pmu_num_decode
  import pmu_gate_pkg::*;
(
  input  logic [NUM_W-1:0] num,
  input  logic             user,
  output idx_t             idx
);
  logic [NUM_W-1:0] pnum;
  idx_t direct, aliased;

  assign pnum = num + NUM_W'(ALIAS_OFS);

  always_comb begin
    direct  = lookup(num);
    aliased = lookup(pnum);
    if (user) idx = (aliased == IX_CTRL1) ? IX_NONE : aliased;
    else      idx = (direct != IX_NONE) ? direct : aliased;
  end
endmodule

// File: rtl/pmu_access_check.sv
module pmu_access_check
  import pmu_gate_pkg::*;
(
  input  idx_t       idx,
  input  logic       wr,
  input  logic       user,
  input  logic [1:0] gate,
  output logic       trap,
  output cause_e     cause
);
  logic hi_cnt;
  assign hi_cnt = (idx >= IX_HI) && (idx < IX_NONE);

  always_comb begin
    trap  = 1'b0;
    cause = CAUSE_FAC;
    if (user && idx != IX_NONE) begin
      if (hi_cnt && gate == 2'b11)    trap = 1'b1;
      else if (gate == 2'b01)         trap = 1'b1;
      else if (wr && gate == 2'b00) begin
        trap  = 1'b1;
        cause = CAUSE_EMU;
      end
    end
  end
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              user,
  input  idx_t              idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cur,
  output logic [1:0]        gate
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] mask, wval;

  assign cur  = (idx < IX_NONE) ? regs_q[idx] : '0;
  assign mask = user_mask(idx);
  assign wval = user ? ((cur & ~mask) | (wdata & mask)) : wdata;
  assign gate = regs_q[IX_CTRL0][GATE_LSB +: 2];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs_q[g] <= '0;
      else if (we && idx == idx_t'(g))    regs_q[g] <= wval;
    end
  end

  // R9
  hold_ctrl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q[IX_CTRL0]));

  // R5
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && user && idx == IX_CTRL0) |=>
      ((regs_q[IX_CTRL0] & ~user_mask(IX_CTRL0)) ==
       ($past(regs_q[IX_CTRL0]) & ~user_mask(IX_CTRL0))));
endmodule

// File: rtl/pmu_gate.sv
module pmu_gate
  import pmu_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              trap_valid,
  output logic              trap_cause
);
  idx_t              idx;
  logic              chk_trap;
  cause_e            chk_cause;
  logic [1:0]        gate;
  logic [DATA_W-1:0] cur, view;
  logic              trap_now, we;

  pmu_num_decode i_dec (.num(req_num), .user(req_user), .idx(idx));

  pmu_access_check i_chk (
    .idx(idx), .wr(req_write), .user(req_user), .gate(gate),
    .trap(chk_trap), .cause(chk_cause)
  );

  assign trap_now = req_valid && chk_trap;
  assign we       = req_valid && req_write && !chk_trap && idx != IX_NONE;

  pmu_bank i_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .user(req_user), .idx(idx),
    .wdata(req_wdata), .cur(cur), .gate(gate)
  );

  assign view = req_user ? (cur & user_mask(idx)) : cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      trap_valid <= 1'b0;
      trap_cause <= 1'b0;
    end else begin
      rsp_valid  <= req_valid && !chk_trap;
      rsp_rdata  <= (req_valid && !chk_trap && !req_write) ? view : '0;
      trap_valid <= trap_now;
      trap_cause <= trap_now && (chk_cause == CAUSE_EMU);
    end
  end

  // R9
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!rsp_valid && rsp_rdata == '0));

  // R11
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || trap_valid) |-> $past(req_valid));

  // R2
  emu_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause) |-> $past(req_write && req_user && gate == 2'b00));

  // R1
  fac_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && !req_write && idx != IX_NONE && gate == 2'b01)
      |=> (trap_valid && !trap_cause));

  // R3
  hi_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && idx >= IX_HI && idx < IX_NONE && gate == 2'b11)
      |=> (trap_valid && !trap_cause));
endmodule

// File: tb/test_pmu_gate.sv
module test_pmu_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [7:0]  req_num = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, trap_valid, trap_cause;
  logic [63:0] rsp_rdata;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmu_gate i_pmu_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_num(req_num), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .trap_valid(trap_valid), .trap_cause(trap_cause)
  );

  typedef struct packed {
    logic        usr; logic wr; logic [7:0] num; logic [63:0] wd;
    logic        etrap; logic ecause; logic [63:0] erd; logic [3:0] req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] C0A  = 64'hAAAA_AAAA_AAA3_AAAA;
  localparam logic [63:0] C0C  = 64'h1234_5678_0008_0000;
  localparam logic [63:0] CNT6 = 64'hDEAD_BEEF_0000_0006;
  localparam int NV = 42;
  // req field: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 checked by entries tagged below
  localparam vec_t VEC [NV] = '{
    '{0,1,8'h1B,C0A,0,0,64'h0,4'd8},                  // R8 gate 00
    '{0,0,8'h1B,64'h0,0,0,C0A,4'd8},                  // R8
    '{1,0,8'h0B,64'h0,0,0,64'h8000_0080,4'd4},        // R4
    '{1,1,8'h0B,ONES,1,1,64'h0,4'd2},                 // R2 gate 00 -> EA
    '{0,0,8'h1B,64'h0,0,0,C0A,4'd9},                  // R9 unchanged
    '{1,1,8'h03,64'h1,1,1,64'h0,4'd2},                // R2
    '{1,0,8'h03,64'h0,0,0,64'h0,4'd1},                // R1 gate 00 read ok
    '{0,1,8'h1B,64'h4_0000,0,0,64'h0,4'd8},           // gate 01
    '{1,0,8'h0B,64'h0,1,0,64'h0,4'd1},                // R1
    '{1,1,8'h01,64'hF,1,0,64'h0,4'd2},                // R2 gate 01 -> FU
    '{1,0,8'h07,64'h0,1,0,64'h0,4'd3},                // R3 gate 01
    '{0,1,8'h1B,C0C,0,0,64'h0,4'd8},                  // gate 10
    '{1,1,8'h0B,ONES,0,0,64'h0,4'd5},                 // R5
    '{0,0,8'h1B,64'h0,0,0,64'h1234_5678_8408_0080,4'd5},
    '{1,1,8'h0B,64'h0,0,0,64'h0,4'd5},
    '{0,0,8'h1B,64'h0,0,0,C0C,4'd5},
    '{0,1,8'h11,ONES,0,0,64'h0,4'd8},
    '{1,0,8'h01,64'h0,0,0,64'h4020_1008_0402_0000,4'd6}, // R6
    '{1,1,8'h01,64'h0,0,0,64'h0,4'd6},
    '{0,0,8'h11,64'h0,0,0,64'hBFDF_EFF7_FBFD_FFFF,4'd6},
    '{1,1,8'h08,CNT6,0,0,64'h0,4'd7},                 // R7
    '{0,0,8'h18,64'h0,0,0,CNT6,4'd7},
    '{1,1,8'h03,64'h1111,0,0,64'h0,4'd7},
    '{0,0,8'h13,64'h0,0,0,64'h1111,4'd7},
    '{1,0,8'h07,64'h0,0,0,64'h0,4'd3},                // R3 gate 10 ok
    '{0,1,8'h1E,64'h5555,0,0,64'h0,4'd8},
    '{1,0,8'h0E,64'h0,0,0,64'h0,4'd10},               // R10
    '{1,1,8'h0E,64'hFFFF,0,0,64'h0,4'd10},
    '{0,0,8'h1E,64'h0,0,0,64'h5555,4'd10},
    '{1,1,8'h1B,ONES,0,0,64'h0,4'd10},
    '{0,0,8'h1B,64'h0,0,0,C0C,4'd10},
    '{1,0,8'h20,64'h0,0,0,64'h0,4'd10},
    '{0,1,8'h1B,64'hC_0000,0,0,64'h0,4'd8},           // gate 11
    '{1,0,8'h08,64'h0,1,0,64'h0,4'd3},                // R3
    '{1,1,8'h07,64'h7,1,0,64'h0,4'd3},
    '{0,0,8'h18,64'h0,0,0,CNT6,4'd9},
    '{1,0,8'h03,64'h0,0,0,64'h1111,4'd3},
    '{1,1,8'h0B,ONES,0,0,64'h0,4'd2},                 // R2 gate 11 ok
    '{0,0,8'h0B,64'h0,0,0,64'h840C_0080,4'd8},        // R8 alias from privileged
    '{1,0,8'h0B,64'h0,0,0,64'h8400_0080,4'd4},
    '{0,1,8'h17,64'hABCD,0,0,64'h0,4'd8},
    '{0,0,8'h17,64'h0,0,0,64'hABCD,4'd8}
  };

  task automatic check(string tag, logic [66:0] act, logic [66:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got rv/tv/tc/data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(logic u, logic w, logic [7:0] n, logic [63:0] d);
    req_valid = 1'b1; req_user = u; req_write = w; req_num = n; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 reset outputs", {rsp_valid, trap_valid, trap_cause, rsp_rdata}, 67'h0);
    op(0, 0, 8'h1B, 0);
    check("R11 control 0 after reset", {rsp_valid, trap_valid, trap_cause, rsp_rdata},
          {3'b100, 64'h0});
    op(0, 0, 8'h15, 0);
    check("R11 counter 3 after reset", {rsp_valid, trap_valid, trap_cause, rsp_rdata},
          {3'b100, 64'h0});

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].usr, VEC[i].wr, VEC[i].num, VEC[i].wd);
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            {rsp_valid, trap_valid, trap_cause, rsp_rdata},
            {!VEC[i].etrap, VEC[i].etrap, VEC[i].ecause, VEC[i].erd});
    end

    // R9 trap pulse lasts one cycle (gate is 11 here)
    op(1, 0, 8'h08, 0);
    check("R9 trap raised", {rsp_valid, trap_valid, trap_cause, rsp_rdata}, {3'b010, 64'h0});
    idle();
    check("R9 trap single cycle", {rsp_valid, trap_valid, trap_cause, rsp_rdata}, 67'h0);
    // R11 response single cycle, back-to-back requests
    op(0, 0, 8'h13, 0);
    op(0, 0, 8'h18, 0);
    check("R11 back-to-back second", {rsp_valid, trap_valid, trap_cause, rsp_rdata},
          {3'b100, CNT6});
    idle();
    check("R11 response single cycle", {rsp_valid, trap_valid, trap_cause, rsp_rdata}, 67'h0);
    // R11 reset clears registers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    op(0, 0, 8'h18, 0);
    check("R11 reset clears counter 6", {rsp_valid, trap_valid, trap_cause, rsp_rdata},
          {3'b100, 64'h0});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule